// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous, pipelined burst SRAM. Reads and writes can follow each other on every clock with no idle cycle between them. Every control and address input is registered on the rising clock edge. Read data leaves through an output register one cycle after its address is taken. Write data arrives two cycles after its address is taken.

The bidirectional data bus is split into a write-data input `d_in`, a registered read-data output `q_out`, and a drive enable `q_oe`. A surrounding pad ring or testbench combines these into a three-state bus. Each data lane is one byte plus its parity bit, so a lane is nine bits wide.

Because write data lags its address, a read can name an address whose write is still in flight. In that case the model returns the in-flight data, merged lane by lane over the stored word. A clock-enable input freezes the whole block, and a chip-select term that needs three inputs to agree allows banks to be stacked.

Top module: `lw_sram`

## Requirements
- R1: An access starts on a rising edge with `cen_n` low, `adv_ld` low and all three selects active (`ce1_n` low, `ce2` high, `ce3_n` low). `we_n` low makes it a write and `we_n` high a read, and a read returns the word last written to that address.
- R2: Read data from an address captured on enabled edge N appears on `q_out` with `q_drive` set after enabled edge N+1.
- R3: The write data for an address captured on enabled edge N is sampled from `d_in` on enabled edge N+2.
- R4: `bw_n[i]` low selects lane i, bits [9i+8:9i], and it is sampled with the address. Lanes that are not selected keep their contents, and `bw_n` all ones writes nothing.
- R5: With `cen_n` high a clock edge changes no state: the pipeline, `q_out`, the drive flag and the burst position all hold, and `d_in` is ignored.
- R6: A deselecting edge (adv_ld low, selects not all active) leaves `q_oe` low after the next enabled edge. The first cycle after leaving deselect is also not driven.
- R7: After the enabled edge that follows a write's address edge, `q_oe` stays low whatever the level of `oe_n`.
- R8: `oe_n` gates `q_oe` combinationally, with no clock. A read with `oe_n` high leaves the bus undriven, and lowering `oe_n` later in that cycle shows the data at once.
- R9: Synchronous active-low reset leaves the block deselected, with `q_oe` low and `q_out` zero.
- R10: A read whose address matches a write that has not yet committed returns the write's selected lanes merged over the stored word.
- R11: With `adv_ld` high an enabled edge continues the current burst. The low two address bits step in linear order with wrap, modulo 4 from the start value. The burst keeps its read or write type, ignores the selects and `we_n`, and continues a deselect if that came last.
- R12: Writes and reads may alternate on consecutive enabled edges with no idle cycle, and each read returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | High: continue burst; low: load new address |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, unclocked |
| q_out | output | LANES*LANE_W | Registered read data |
| q_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions relate sampled control inputs to the output drive one or two enabled edges later. They assume the inputs are stable and known around each rising edge. They also assume that no capture made while reset was low counts as an access. The stimulus meets both assumptions by changing every input on the falling edge and by holding all selects inactive until reset is released. The stimulus also writes every address before it reads any, so no read can return an unwritten word.

// File: rtl/lw_sram_pkg.sv
// Shared definitions for the late-write SRAM model.
// Assumes: burst length is fixed at four, so only the low two address bits step.
package lw_sram_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    localparam int BURST_BITS = 2;

    // Low address bits for a given burst step from a start value.
    function automatic logic [BURST_BITS-1:0] burst_lo(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input burst_order_e          order
    );
        return (order == ORDER_INTERLEAVED) ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/lw_sram_seq.sv
// Access sequencer: decides which operation an enabled edge captures.
// A load (adv_ld low) takes address, selects and write enable from the pins.
// A continue (adv_ld high) steps the burst position and reuses the type and
// the select outcome of the last load.
// Assumes: ADDR_W >= 3; bw_n is sampled fresh on every edge.
module lw_sram_seq
    import lw_sram_pkg::*;
#(
    parameter int           ADDR_W = 6,
    parameter int           LANES  = 4,
    parameter burst_order_e ORDER  = ORDER_LINEAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              op_valid,
    output logic              op_write,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_mask
);

    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] step_q;
    logic [BURST_BITS-1:0] step_nx;
    logic                  wr_q;
    logic                  act_q;

    assign step_nx = step_q + 1'b1;

    // Select the operation for this edge: fresh load or burst continuation.
    always_comb begin
        if (!adv_ld) begin
            op_valid = sel;
            op_write = !we_n;
            op_addr  = addr;
        end else begin
            op_valid = act_q;
            op_write = wr_q;
            op_addr  = {base_q[ADDR_W-1:BURST_BITS],
                        burst_lo(base_q[BURST_BITS-1:0], step_nx, ORDER)};
        end
        op_mask = (op_valid && op_write) ? ~bw_n : '0;
    end

    // Burst state: reload on a load edge, advance on a continue edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            step_q <= '0;
            wr_q   <= 1'b0;
            act_q  <= 1'b0;
        end else if (en) begin
            if (!adv_ld) begin
                base_q <= addr;
                step_q <= '0;
                wr_q   <= !we_n;
                act_q  <= sel;
            end else begin
                step_q <= step_nx;
            end
        end
    end

endmodule

// File: rtl/lw_sram_store.sv
// Storage array split into one memory per lane, with per-lane write and a
// read port that merges in-flight write data over stored lanes.
// Assumes: the array is not reset; the caller gates wr_en with clock enable.
module lw_sram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      byp_hit,
    input  logic [LANES-1:0]          byp_mask,
    input  logic [LANES*LANE_W-1:0]   byp_data,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: only when this lane is selected.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) begin
                mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        // Lane read: pending write data replaces the stored lane on a hit.
        always_comb begin
            if (byp_hit && byp_mask[l]) begin
                rd_data[l*LANE_W +: LANE_W] = byp_data[l*LANE_W +: LANE_W];
            end else begin
                rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
            end
        end
    end

endmodule

// File: rtl/lw_sram.sv
// Pipelined late-write synchronous SRAM, top level.
// Stage 1 holds the operation captured on the last enabled edge. Stage 2
// holds the one before it. A stage-2 write commits with d_in on the current
// enabled edge, and a stage-1 read loads the output register on that same
// edge. Read data therefore trails its address by one edge, and write data
// by two.
// Assumes: inputs settle before each rising edge; oe_n may change anytime.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int           ADDR_W = 6,
    parameter int           LANES  = 4,
    parameter int           LANE_W = 9,
    parameter burst_order_e ORDER  = ORDER_LINEAR
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] d_in,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] q_out,
    output logic                    q_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              sel_all;
    logic              nx_valid, nx_write;
    logic [ADDR_W-1:0] nx_addr;
    logic [LANES-1:0]  nx_mask;

    logic              s1_valid, s1_write;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic              s2_valid, s2_write;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_mask;

    logic              commit;
    logic              hit;
    logic [DATA_W-1:0] rd_word;
    logic              drive_q;

    assign en      = !cen_n;
    assign sel_all = !ce1_n && ce2 && !ce3_n;
    assign commit  = en && s2_valid && s2_write;
    assign hit     = s2_valid && s2_write && (s2_addr == s1_addr);

    lw_sram_seq #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .ORDER  (ORDER)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sel      (sel_all),
        .adv_ld   (adv_ld),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .addr     (addr),
        .op_valid (nx_valid),
        .op_write (nx_write),
        .op_addr  (nx_addr),
        .op_mask  (nx_mask)
    );

    lw_sram_store #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_store (
        .clk      (clk),
        .wr_en    (commit),
        .wr_addr  (s2_addr),
        .wr_mask  (s2_mask),
        .wr_data  (d_in),
        .rd_addr  (s1_addr),
        .byp_hit  (hit),
        .byp_mask (s2_mask),
        .byp_data (d_in),
        .rd_data  (rd_word)
    );

    // Operation pipeline: advance both stages on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_write <= 1'b0;
            s1_addr  <= '0;
            s1_mask  <= '0;
            s2_valid <= 1'b0;
            s2_write <= 1'b0;
            s2_addr  <= '0;
            s2_mask  <= '0;
        end else if (en) begin
            s1_valid <= nx_valid;
            s1_write <= nx_write;
            s1_addr  <= nx_addr;
            s1_mask  <= nx_mask;
            s2_valid <= s1_valid;
            s2_write <= s1_write;
            s2_addr  <= s1_addr;
            s2_mask  <= s1_mask;
        end
    end

    // Output register and drive flag, loaded by a stage-1 read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            q_out   <= '0;
        end else if (en) begin
            drive_q <= s1_valid && !s1_write;
            if (s1_valid && !s1_write) begin
                q_out <= rd_word;
            end
        end
    end

    assign q_oe = drive_q && !oe_n;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!drive_q && !q_oe && q_out == '0)); // R9

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(rst_n) && $past(en && !adv_ld && sel_all && we_n)) |=> drive_q); // R2

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(rst_n) && $past(en && !adv_ld && sel_all && !we_n)) |=> !q_oe); // R7

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(rst_n) && $past(en && !adv_ld && !sel_all)) |=> !q_oe); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cen_n)) |-> ($stable(q_out) && $stable(drive_q))); // R5

endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, cen_n, ce1_n, ce2, ce3_n, adv_ld, we_n, oe_n;
    logic [LN-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in, q_out;
    logic          q_oe;

    always #10 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .d_in(d_in), .oe_n(oe_n), .q_out(q_out), .q_oe(q_oe)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state, built from the requirements.
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m1v = 0, m1w = 0, m2v = 0, m2w = 0;
    logic [AW-1:0] m1a = '0, m2a = '0;
    logic [LN-1:0] m1m = '0, m2m = '0;
    logic [DW-1:0] m1d = '0, m2d = '0;
    logic          bact = 0, bwr = 0;
    logic [AW-1:0] bbase = '0;
    logic [1:0]    bcnt = '0;
    logic          exp_drive = 0;
    logic [DW-1:0] exp_q = '0;

    function automatic logic [DW-1:0] pat(input int a, input int s);
        logic [DW-1:0] v;
        v = DW'(a) * 36'h0_2E5_B3C7 + DW'(s) * 36'h9_1A2B_C3D;
        return v ^ (v >> 11);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs at the falling edge, model the rising edge,
    // check outputs at the following falling edge.
    task automatic step(input bit cen, input bit sel, input bit adv, input bit we,
                        input logic [LN-1:0] bwn, input int a,
                        input logic [DW-1:0] wd, input bit oe, input string tag);
        bit            cv, cw;
        logic [AW-1:0] ca;
        logic [LN-1:0] cm;
        cen_n  = cen;
        ce1_n  = !sel;
        ce2    = sel;
        ce3_n  = !sel;
        adv_ld = adv;
        we_n   = we;
        bw_n   = bwn;
        addr   = AW'(a);
        oe_n   = oe;
        if (cen)                d_in = ~m2d;       // R5: ignored while stalled
        else if (m2v && m2w)    d_in = m2d;
        else                    d_in = pat(99, 7);
        @(posedge clk);
        if (!cen) begin
            if (!adv) begin
                cv = sel; cw = !we; ca = AW'(a);
                bbase = AW'(a); bcnt = 2'd0; bwr = !we; bact = sel;
            end else begin
                cv = bact; cw = bwr;
                bcnt = bcnt + 2'd1;
                ca = {bbase[AW-1:2], 2'(bbase[1:0] + bcnt)};
            end
            cm = cw ? ~bwn : '0;
            if (m2v && m2w)
                for (int l = 0; l < LN; l++)
                    if (m2m[l]) ref_mem[m2a][l*LW +: LW] = d_in[l*LW +: LW];
            exp_drive = m1v && !m1w;
            if (exp_drive) exp_q = ref_mem[m1a];
            m2v = m1v; m2w = m1w; m2a = m1a; m2m = m1m; m2d = m1d;
            m1v = cv;  m1w = cw;  m1a = ca;  m1m = cm;  m1d = wd;
        end
        @(negedge clk);
        check({tag, " q_oe"}, DW'(q_oe), DW'(exp_drive && !oe));
        if (exp_drive) check({tag, " q_out"}, q_out, exp_q);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 1, '1, 0, '0, 0, tag);
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv_ld = 0;
        we_n = 1; bw_n = '1; addr = '0; oe_n = 0; d_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset q_oe", DW'(q_oe), '0);
        check("R9 reset q_out", q_out, '0);
        rst_n = 1;
        idle("R9 after reset");
        idle("R6 deselected");

        // R1 R3 R7: fill every address with back-to-back writes.
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 0, '0, a, pat(a, 1), 0, "R3 R7 fill");
        idle("R6"); idle("R6");
        // R1 R2: read every address back to back.
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 1, '1, a, '0, 0, "R1 R2 read sweep");
        idle("R6"); idle("R6");

        // R10 R12: alternate write and read, same address then a neighbour.
        for (int i = 0; i < 32; i++) begin
            step(0, 1, 0, 0, '0, i, pat(i, 2), 0, "R12 write");
            step(0, 1, 0, 1, '1, i, '0, 0, "R10 bypass read");
            step(0, 1, 0, 0, 4'(i), i + 1, pat(i, 3), 0, "R12 partial write");
            step(0, 1, 0, 1, '1, (i + 1) % DEPTH, '0, 0, "R10 R12 merged read");
        end
        idle("R6"); idle("R6");

        // R4: every lane mask, including the all-ones abort.
        for (int m = 0; m < 16; m++) begin
            step(0, 1, 0, 0, 4'(m), 5, pat(m, 50), 0, "R4 masked write");
            idle("R4");
            step(0, 1, 0, 1, '1, 5, '0, 0, "R4 masked read");
            idle("R4");
            idle("R4");
        end

        // R5: stall between a write address and its data, and during a read.
        step(0, 1, 0, 0, '0, 9, pat(9, 60), 0, "R5 write");
        step(1, 1, 0, 1, '1, 3, '0, 0, "R5 stall");
        step(1, 0, 0, 0, '0, 4, '0, 0, "R5 stall");
        idle("R5"); idle("R5");
        step(0, 1, 0, 1, '1, 9, '0, 0, "R5 read");
        idle("R5");
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, '0, 1, '0, 0, "R5 hold output");
        step(0, 1, 0, 1, '1, 10, '0, 0, "R5 read after stall");
        idle("R6"); idle("R6");

        // R6: read then deselect; read right after deselect.
        step(0, 1, 0, 1, '1, 3, '0, 0, "R6 read");
        idle("R6 pipelined deselect");
        idle("R6 bus released");
        step(0, 1, 0, 1, '1, 4, '0, 0, "R6 first cycle after deselect");
        idle("R6"); idle("R6");

        // R8: dummy read, then lower oe_n inside the cycle.
        step(0, 1, 0, 1, '1, 12, '0, 1, "R8 dummy read");
        step(0, 0, 0, 1, '1, 0, '0, 1, "R8 oe high");
        oe_n = 0; #1;
        check("R8 oe low q_oe", DW'(q_oe), DW'(1));
        check("R8 oe low q_out", q_out, ref_mem[12]);
        oe_n = 1; #1;
        check("R8 oe high q_oe", DW'(q_oe), '0);
        idle("R8");

        // R11: four-beat write burst from 6 (6,7,4,5) with selects and
        // write enable ignored on continue edges, then a read burst.
        step(0, 1, 0, 0, '0, 6, pat(6, 70), 0, "R11 burst write load");
        for (int k = 1; k < 4; k++) step(0, 0, 1, 1, '0, 0, pat(k, 71), 0, "R11 burst write continue");
        step(0, 1, 0, 1, '1, 6, '0, 0, "R11 burst read load");
        for (int k = 1; k < 4; k++) step(0, 0, 1, 0, '0, 0, '0, 0, "R11 burst read continue");
        idle("R11");
        step(0, 0, 1, 0, '0, 0, '0, 0, "R11 continue after deselect");
        idle("R11");
        for (int a = 4; a < 8; a++) step(0, 1, 0, 1, '1, a, '0, 0, "R11 burst readback");
        idle("R6"); idle("R6");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule